// File: doc/BRIEF.md
# Power schedule sequencer

This block replays a fixed, repeating power schedule so that a host microcontroller can remain in its deepest sleep state. It owns one enable line per peripheral device and a small internal program memory of 16-bit instructions. While the sequencer is idle, the host fills that memory through a plain write port. A pulse on the start input then begins execution at address 0. From that point the sequencer runs on its own until the next reset.

Each instruction has an operation byte and a delay byte. The operation can set one device enable high or low, jump to a subroutine, or return from it. The return waits until a chosen interrupt code arrives. The delay byte is a compact pseudo-floating cycle count. After any instruction executes, the sequencer waits out that count before it fetches the next instruction. Only one call level exists. The current program counter is brought out as a debug aid.

Top module: `pwr_sched_seq`

## Requirements
- R1: While reset is asserted, and after it until start is seen, every device enable is 0, the program counter reads 0 and no instruction executes.
- R2: A 1 on start while idle begins execution at address 0. The first instruction takes effect at the second rising edge after start is sampled.
- R3: Opcode bits 15:14 select the operation: 00 switch, 01 call, 10 return. A switch instruction writes bit 13 into the enable selected by bits 12:8 and leaves every other enable unchanged.
- R4: Delay byte bits 7:3 form e and bits 2:0 form m. The wait is 2^e + floor(m·2^e / 8) cycles. Each instruction therefore occupies 1 + wait cycles between successive executions.
- R5: A call loads the program counter with four times bits 13:8 and stores the address that follows the call as the single return address.
- R6: A return holds the program counter, with no further effect, until irqValid is 1 with irqCode equal to bits 13:8. It then loads the stored return address and waits out its delay.
- R7: Program memory writes presented while the sequencer is running are discarded and do not alter later execution.
- R8: Opcode 11 changes no enable and simply advances the program counter by one, followed by its delay.
- R9: Every switch or return instruction that executes advances the program counter to the following address, except that a return loads the stored return address instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution at address 0 when idle |
| progWe | input | 1 | Program memory write enable (honoured only while idle) |
| progAddr | input | $clog2(PROG_DEPTH) | Program memory write address |
| progData | input | 16 | Instruction word to write |
| irqValid | input | 1 | An interrupt code is present this cycle |
| irqCode | input | 6 | Interrupt code compared by the return instruction |
| devEn | output | NUM_DEV | Registered device power enables |
| pc | output | $clog2(PROG_DEPTH) | Program counter for debug |

## Verification
The delay decoder is driven with a table of delay bytes. The table covers small exponents, where the fraction term is truncated or vanishes, and larger ones, where it adds exactly. Measuring the time from an enable rising to the same enable falling separates a correct decode from an off-by-one counter or a mis-shifted fraction. The program patterns are chosen to tell the operations apart. A reserved opcode whose bits would select the top device if misdecoded checks that it is a no-op. A call into a subroutine that ends in a return is checked against a wrong interrupt code and then the right one, which shows that the return address is pc+1. A write aimed at a not-yet-executed address during a long delay shows whether the memory is protected while the sequencer runs.

// File: rtl/pwr_sched_pkg.sv
package pwr_sched_pkg;

  localparam int INSTR_W   = 16;
  localparam int DLY_BYTE_W = 8;
  localparam int EXP_W     = 5;
  localparam int MANT_W    = 3;
  localparam int ARG_W     = 6;
  localparam int DEV_SEL_W = 5;
  localparam int CNT_W     = 1 << EXP_W;

  typedef enum logic [1:0] {
    OP_SWITCH = 2'b00,
    OP_GOSUB  = 2'b01,
    OP_RETI   = 2'b10,
    OP_RSVD   = 2'b11
  } opKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic pcClear;
    logic execute;
    logic countEn;
    logic running;
  } seqStrobe_t;

  // decoded view of one instruction word
  typedef struct packed {
    opKind_e               kind;
    logic [ARG_W-1:0]      arg;
    logic [DLY_BYTE_W-1:0] dly;
  } instrFields_t;

  // pseudo-floating delay: 2^e + (m * 2^e) / 8, truncated
  function automatic logic [CNT_W-1:0] decodeDelay(input logic [DLY_BYTE_W-1:0] code);
    logic [EXP_W-1:0]        e;
    logic [MANT_W-1:0]       m;
    logic [CNT_W+MANT_W-1:0] whole;
    logic [CNT_W+MANT_W-1:0] frac;
    e     = code[DLY_BYTE_W-1:MANT_W];
    m     = code[MANT_W-1:0];
    whole = (CNT_W+MANT_W)'(1) << e;
    frac  = ((CNT_W+MANT_W)'(m) << e) >> MANT_W;
    return CNT_W'(whole + frac);
  endfunction

endpackage

// File: rtl/pwr_sched_ctrl.sv
module pwr_sched_ctrl
  import pwr_sched_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  opKind_e    kind,
  input  logic       irqHit,
  input  logic       cntDone,
  output seqStrobe_t strobes
);

  typedef enum logic [1:0] {
    S_IDLE  = 2'b00,
    S_EXEC  = 2'b01,
    S_DELAY = 2'b10
  } seqState_e;

  seqState_e stateQ, stateNxt;

  always_comb begin
    strobes  = '0;
    stateNxt = stateQ;
    unique case (stateQ)
      S_IDLE: begin
        if (start) begin
          strobes.pcClear = 1'b1;
          stateNxt        = S_EXEC;
        end
      end
      S_EXEC: begin
        strobes.running = 1'b1;
        // a return stays here until its interrupt code matches
        if (!(kind == OP_RETI && !irqHit)) begin
          strobes.execute = 1'b1;
          stateNxt        = S_DELAY;
        end
      end
      S_DELAY: begin
        strobes.running = 1'b1;
        strobes.countEn = 1'b1;
        if (cntDone) stateNxt = S_EXEC;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateNxt;
  end

  // R2: execution never begins without a start pulse
  p_start_needed_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_IDLE && !start) |=> !strobes.execute);

endmodule

// File: rtl/pwr_sched_dp.sv
module pwr_sched_dp
  import pwr_sched_pkg::*;
#(
  parameter int NUM_DEV    = 32,
  parameter int PROG_DEPTH = 32,
  localparam int AW        = $clog2(PROG_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobes,
  input  logic               progWe,
  input  logic [AW-1:0]      progAddr,
  input  logic [INSTR_W-1:0] progData,
  input  logic               irqValid,
  input  logic [ARG_W-1:0]   irqCode,
  output opKind_e            kind,
  output logic               irqHit,
  output logic               cntDone,
  output logic [NUM_DEV-1:0] devEn,
  output logic [AW-1:0]      pc
);

  logic [INSTR_W-1:0] progMem [PROG_DEPTH];
  logic [AW-1:0]      pcQ;
  logic [AW-1:0]      retQ;
  logic [CNT_W-1:0]   cntQ;
  logic [NUM_DEV-1:0] devEnQ;
  instrFields_t       cur;

  // host load port, locked while the schedule runs
  always_ff @(posedge clk) begin
    if (progWe && !strobes.running) progMem[progAddr] <= progData;
  end

  assign cur    = instrFields_t'(progMem[pcQ]);
  assign kind   = cur.kind;
  assign irqHit = irqValid && (irqCode == cur.arg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ <= '0;
    end else if (strobes.pcClear) begin
      pcQ <= '0;
    end else if (strobes.execute) begin
      unique case (cur.kind)
        OP_GOSUB: pcQ <= AW'({cur.arg, 2'b00});
        OP_RETI:  pcQ <= retQ;
        default:  pcQ <= pcQ + AW'(1);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                      retQ <= '0;
    else if (strobes.execute && cur.kind == OP_GOSUB) retQ <= pcQ + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                cntQ <= '0;
    else if (strobes.execute) cntQ <= decodeDelay(cur.dly);
    else if (strobes.countEn) cntQ <= cntQ - CNT_W'(1);
  end

  assign cntDone = (cntQ == CNT_W'(1));

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    always_ff @(posedge clk) begin
      if (!rstN)
        devEnQ[g] <= 1'b0;
      else if (strobes.execute && cur.kind == OP_SWITCH &&
               cur.arg[DEV_SEL_W-1:0] == DEV_SEL_W'(g))
        devEnQ[g] <= cur.arg[DEV_SEL_W];
    end
  end

  assign devEn = devEnQ;
  assign pc    = pcQ;

  // R3: at most one enable toggles per cycle
  p_one_enable_r3: assert property (@(posedge clk) disable iff (!rstN)
    $countones(devEnQ ^ $past(devEnQ)) <= 1);

  // R4: program counter frozen while a delay counts
  p_pc_frozen_delay_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.countEn |=> $stable(pcQ));

  // R5: a call lands on four times its argument
  p_call_target_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.execute && cur.kind == OP_GOSUB) |=> pcQ == AW'({$past(cur.arg), 2'b00}));

  // R6: while running, the pc moves only when an instruction executes
  p_pc_moves_on_exec_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.running && !strobes.execute) |=> $stable(pcQ));

  // R7: memory contents untouched by writes during a run
  p_write_locked_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.running && progWe) |=> progMem[$past(progAddr)] == $past(progMem[progAddr]));

endmodule

// File: rtl/pwr_sched_seq.sv
module pwr_sched_seq
  import pwr_sched_pkg::*;
#(
  parameter int NUM_DEV    = 32,
  parameter int PROG_DEPTH = 32,
  localparam int AW        = $clog2(PROG_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               progWe,
  input  logic [AW-1:0]      progAddr,
  input  logic [15:0]        progData,
  input  logic               irqValid,
  input  logic [5:0]         irqCode,
  output logic [NUM_DEV-1:0] devEn,
  output logic [AW-1:0]      pc
);

  seqStrobe_t strobes;
  opKind_e    kind;
  logic       irqHit;
  logic       cntDone;

  pwr_sched_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .kind    (kind),
    .irqHit  (irqHit),
    .cntDone (cntDone),
    .strobes (strobes)
  );

  pwr_sched_dp #(
    .NUM_DEV    (NUM_DEV),
    .PROG_DEPTH (PROG_DEPTH)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .progWe   (progWe),
    .progAddr (progAddr),
    .progData (progData),
    .irqValid (irqValid),
    .irqCode  (irqCode),
    .kind     (kind),
    .irqHit   (irqHit),
    .cntDone  (cntDone),
    .devEn    (devEn),
    .pc       (pc)
  );

endmodule

// File: tb/pwr_sched_seq_tb_top.sv
`timescale 1ns/1ps
module pwr_sched_seq_tb_top;

  localparam int NUM_DEV    = 32;
  localparam int PROG_DEPTH = 32;
  localparam int AW         = $clog2(PROG_DEPTH);
  localparam int N_VEC      = 10;

  // {delay byte, expected wait in cycles}
  localparam logic [23:0] DLY_VEC [N_VEC] = '{
    24'h00_0001, 24'h07_0001, 24'h0F_0003, 24'h17_0007, 24'h1C_000C,
    24'h2D_0034, 24'h38_0080, 24'h43_0160, 24'h11_0004, 24'h0C_0003
  };

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               start = 1'b0;
  logic               progWe = 1'b0;
  logic [AW-1:0]      progAddr = '0;
  logic [15:0]        progData = '0;
  logic               irqValid = 1'b0;
  logic [5:0]         irqCode = '0;
  logic [NUM_DEV-1:0] devEn;
  logic [AW-1:0]      pc;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pwr_sched_seq #(.NUM_DEV(NUM_DEV), .PROG_DEPTH(PROG_DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .progWe(progWe),
    .progAddr(progAddr), .progData(progData), .irqValid(irqValid),
    .irqCode(irqCode), .devEn(devEn), .pc(pc)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk) rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic loadWord(input int addr, input logic [15:0] word);
    @(negedge clk);
    progWe = 1'b1; progAddr = AW'(addr); progData = word;
    @(negedge clk);
    progWe = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state and idling without start
    doReset();
    @(negedge clk);
    check("R1", 64'(devEn), 64'h0);
    check("R1", 64'(pc), 64'h0);
    loadWord(0, 16'h2000);
    repeat (5) @(negedge clk);
    check("R1", 64'(devEn), 64'h0);
    check("R2", 64'(pc), 64'h0);

    // R4: delay decode table, enable high time = 1 + wait
    for (int v = 0; v < N_VEC; v++) begin
      int cnt;
      doReset();
      loadWord(0, {8'h20, DLY_VEC[v][23:16]});
      loadWord(1, 16'h0000);
      loadWord(2, 16'hBF00);
      pulseStart();
      cnt = 0;
      while (devEn[0] !== 1'b1 && cnt < 50) begin @(negedge clk); cnt++; end
      cnt = 0;
      while (devEn[0] !== 1'b0 && cnt < 1000) begin @(negedge clk); cnt++; end
      check("R4", 64'(cnt), 64'(DLY_VEC[v][15:0]) + 64'd1);
      repeat (3) @(negedge clk);
      check("R9", 64'(pc), 64'h2);
    end

    // R8/R3: reserved opcode is a no-op, switch touches one enable
    doReset();
    loadWord(0, 16'hFF00);
    loadWord(1, 16'h2400);
    loadWord(2, 16'hBF00);
    pulseStart();
    repeat (10) @(negedge clk);
    check("R8", 64'(devEn), 64'h10);
    check("R3", 64'(pc), 64'h2);

    // R7: write during a long delay must not land
    doReset();
    loadWord(0, 16'h2138);
    loadWord(1, 16'h2200);
    loadWord(2, 16'hBF00);
    pulseStart();
    repeat (5) @(negedge clk);
    loadWord(1, 16'h2300);
    repeat (200) @(negedge clk);
    check("R7", 64'(devEn), 64'h6);
    check("R7", 64'(pc), 64'h2);

    // R5/R6: call, wait for matching interrupt, return to pc+1
    doReset();
    loadWord(0, 16'h4100);
    loadWord(1, 16'h2300);
    loadWord(2, 16'hBF00);
    loadWord(4, 16'h2200);
    loadWord(5, 16'h8500);
    pulseStart();
    repeat (20) @(negedge clk);
    check("R5", 64'(pc), 64'h5);
    check("R5", 64'(devEn), 64'h4);
    irqValid = 1'b1; irqCode = 6'd6;
    repeat (5) @(negedge clk);
    check("R6", 64'(pc), 64'h5);
    check("R6", 64'(devEn), 64'h4);
    irqCode = 6'd5;
    @(negedge clk);
    irqValid = 1'b0; irqCode = 6'd0;
    check("R6", 64'(pc), 64'h1);
    repeat (10) @(negedge clk);
    check("R6", 64'(devEn), 64'hC);
    check("R9", 64'(pc), 64'h2);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule